// File: doc/BRIEF.md
# Receive Double Buffer with Clock-Stall Flow Control

This block is the storage stage on the receive side of a serial channel. It sits between a deserializer and the CPU's register interface. Each time the deserializer completes a frame, it pulses a strobe with a 9-bit word: eight data bits plus a ninth bit, which is parity in 8-bit mode or the top data bit in 9-bit mode. The word lands in a first-stage holding register. From there it moves into a CPU-visible second-stage register or, when enabled, into a small receive FIFO with a programmable fill threshold.

When the channel generates the serial clock itself in synchronous mode, the block raises a stall request whenever its storage is exhausted. The CPU read that frees space drops the request again, so no word is ever lost. In every other mode a word that finds no free first stage is dropped and an overrun flag is set. The flag is a separate one when the FIFO is in use.

The block also produces a one-cycle receive interrupt each time a word becomes readable. In 9-bit mode a wake-up filter suppresses that interrupt for words whose ninth bit is 0. A synchronous flush empties both stages and the FIFO.

Top module: `rx_dbuf`

## Requirements
- R1: With the FIFO off, `rd_word` shows the readable stage while `data_avail` is 1. A `rd_data` pulse consumes that word, and `data_avail` falls unless another word moves in.
- R2: A completed frame is accepted into the first stage while the second stage still holds an unread word, without setting any overrun flag.
- R3: With the FIFO off, a frame that arrives while the first stage is occupied is dropped and sets `ovr_err`. The unread word, including its ninth bit, stays unchanged, and `ovr_err` stays set until cleared.
- R4: With `clk_out_mode`=1, `stage2_en`=0 and `fifo_en`=0, `stall_req` rises after every frame, the CPU reads the first stage directly, and that read drops `stall_req`. `stall_req` is always 0 when `clk_out_mode`=0.
- R5: With `clk_out_mode`=1, `stage2_en`=1 and `fifo_en`=0, `stall_req` is 1 exactly while both stages are full. A read moves the first stage into the second, pulses `rx_irq` and drops `stall_req`.
- R6: With `fifo_en`=1, words pass from the second stage into the FIFO while it holds fewer than the threshold. Reads return them in arrival order, and `fifo_count` never exceeds DEPTH.
- R7: With `fifo_en`=1, a frame that arrives while the FIFO is at threshold and both stages are full sets `fifo_ovr_err` and leaves the FIFO contents intact.
- R8: With `clk_out_mode`=1 and `fifo_en`=1, `stall_req` is 1 while the FIFO is at threshold and both stages are full. If `auto_rx_off`=1, `rx_en_clear` pulses for one cycle as `stall_req` rises.
- R9: The ninth bit is stored with its word and returned as `rd_word[8]`.
- R10: With `wake_en`=1 and `nine_bit_mode`=1, `rx_irq` fires only for words whose bit 8 is 1. Other words are still stored.
- R11: `rx_irq` is a one-cycle pulse, high in the first cycle a word is readable: on entry to the FIFO, to the second stage, or to the first stage when the second stage is bypassed.
- R12: A `rd_status` pulse clears `ovr_err` and `fifo_ovr_err` unless a new drop happens in the same cycle.
- R13: `flush` (synchronous) and `rst_n` (asynchronous) empty both stages and the FIFO and clear both error flags, `rx_irq` and `stall_req`.
- R14: A `fill_lvl` of 0 or above DEPTH acts as DEPTH. Values 1..DEPTH set the threshold directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all storage and flags |
| frame_vld | input | 1 | Frame-complete strobe from the deserializer |
| frame_word | input | W | Received word, bit 8 is the ninth bit |
| clk_out_mode | input | 1 | Channel drives the serial clock (synchronous) |
| stage2_en | input | 1 | Enable second stage in clock-out mode |
| fifo_en | input | 1 | Route words through the receive FIFO |
| wake_en | input | 1 | Wake-up interrupt filter enable |
| nine_bit_mode | input | 1 | 9-bit word mode |
| auto_rx_off | input | 1 | Request receiver disable when stalling with FIFO |
| fill_lvl | input | CW | FIFO threshold, 0 means DEPTH |
| rd_data | input | 1 | CPU read strobe of the data address |
| rd_status | input | 1 | CPU read strobe of the status address |
| rd_word | output | W | Data returned on the data address |
| data_avail | output | 1 | A readable word is present |
| stall_req | output | 1 | Stop the generated serial clock |
| rx_irq | output | 1 | Receive interrupt pulse |
| ovr_err | output | 1 | Overrun flag (FIFO off) |
| fifo_ovr_err | output | 1 | FIFO overrun flag |
| fifo_count | output | CW | Words held in the FIFO |
| rx_en_clear | output | 1 | Pulse asking the receive-enable bit to be cleared |

## Verification
The bench builds the block with W=9 and DEPTH=4. With that depth it can fill the FIFO to its full depth through the threshold-0 setting, and it can hit the threshold of 2 with the second stage holding back. Those are the cases where the FIFO overrun and the clock-stall paths meet. A behavioural model built on a queue tracks every mode the bench switches through. Directed checks cover the drop-keeps-old-word case, the read that moves the first stage forward, and the wake-up filter on bit 8.

// File: rtl/rx_dbuf_pkg.sv
package rx_dbuf_pkg;

  typedef enum logic [1:0] {
    SRC_STAGE1 = 2'd0,
    SRC_STAGE2 = 2'd1,
    SRC_FIFO   = 2'd2
  } rd_src_e;

  // Interrupt qualifier: with wake-up active in 9-bit mode only words
  // carrying a set ninth bit are announced.
  function automatic logic wake_pass(input logic wake, input logic nine,
                                     input logic top_bit);
    return !(wake && nine) || top_bit;
  endfunction

endpackage

// File: rtl/rx_dbuf_fifo.sv
module rx_dbuf_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_word,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (push || pop) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr_q] <= push_word;
  end

  assign head  = mem[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/rx_dbuf_ctrl.sv
module rx_dbuf_ctrl #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_out_mode,
  input  logic          stage2_en,
  input  logic          fifo_en,
  input  logic          s1_full,
  input  logic          s2_full,
  input  logic [CW-1:0] fifo_count,
  input  logic [CW-1:0] fill_lvl,
  output logic          use_s2,
  output logic [CW-1:0] thr,
  output logic          stall
);

  always_comb begin
    use_s2 = !clk_out_mode || stage2_en || fifo_en;
    thr    = (fill_lvl == '0 || fill_lvl > CW'(DEPTH)) ? CW'(DEPTH) : fill_lvl;
    if (!clk_out_mode)  stall = 1'b0;
    else if (!use_s2)   stall = s1_full;
    else if (!fifo_en)  stall = s1_full && s2_full;
    else                stall = (fifo_count >= thr) && s1_full && s2_full;
  end

endmodule

// File: rtl/rx_dbuf.sv
module rx_dbuf
  import rx_dbuf_pkg::*;
#(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          frame_vld,
  input  logic [W-1:0]  frame_word,
  input  logic          clk_out_mode,
  input  logic          stage2_en,
  input  logic          fifo_en,
  input  logic          wake_en,
  input  logic          nine_bit_mode,
  input  logic          auto_rx_off,
  input  logic [CW-1:0] fill_lvl,
  input  logic          rd_data,
  input  logic          rd_status,
  output logic [W-1:0]  rd_word,
  output logic          data_avail,
  output logic          stall_req,
  output logic          rx_irq,
  output logic          ovr_err,
  output logic          fifo_ovr_err,
  output logic [CW-1:0] fifo_count,
  output logic          rx_en_clear
);

  logic [W-1:0]  s1_q, s2_q, head;
  logic          s1_v_q, s2_v_q, s1_v_d, s2_v_d;
  logic          ovr_q, ovr_d, fovr_q, fovr_d, irq_q, irq_d, stall_q;
  logic          use_s2, stall, pop, push, s2_rd, s1_rd, mv, take, drop;
  logic [CW-1:0] thr, cnt, cnt_a;
  rd_src_e       src;

  rx_dbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_out_mode(clk_out_mode), .stage2_en(stage2_en), .fifo_en(fifo_en),
    .s1_full(s1_v_q), .s2_full(s2_v_q), .fifo_count(cnt), .fill_lvl(fill_lvl),
    .use_s2(use_s2), .thr(thr), .stall(stall)
  );

  rx_dbuf_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .push_word(s2_q),
    .pop(pop), .head(head), .count(cnt)
  );

  // Stage movement, evaluated from the FIFO end backwards so that space
  // freed in one place can be used upstream within the same cycle.
  always_comb begin
    pop    = rd_data && fifo_en && (cnt != '0);
    cnt_a  = cnt - CW'(pop);
    push   = fifo_en && s2_v_q && (cnt_a < thr);
    s2_rd  = !fifo_en && use_s2 && rd_data;
    mv     = use_s2 && s1_v_q && (!s2_v_q || push || s2_rd);
    s2_v_d = mv || (s2_v_q && !push && !s2_rd);
    s1_rd  = !use_s2 && rd_data;
    take   = frame_vld && (!s1_v_q || mv || s1_rd);
    drop   = frame_vld && !take;
    s1_v_d = take || (s1_v_q && !mv && !s1_rd);
    irq_d  = (push && wake_pass(wake_en, nine_bit_mode, s2_q[W-1]))
          || (mv && !fifo_en && wake_pass(wake_en, nine_bit_mode, s1_q[W-1]))
          || (take && !use_s2 && wake_pass(wake_en, nine_bit_mode, frame_word[W-1]));
    ovr_d  = (drop && !fifo_en) || (ovr_q && !rd_status);
    fovr_d = (drop && fifo_en) || (fovr_q && !rd_status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0; s2_v_q <= 1'b0; ovr_q <= 1'b0; fovr_q <= 1'b0;
      irq_q  <= 1'b0; stall_q <= 1'b0;
    end else if (flush) begin
      s1_v_q <= 1'b0; s2_v_q <= 1'b0; ovr_q <= 1'b0; fovr_q <= 1'b0;
      irq_q  <= 1'b0; stall_q <= 1'b0;
    end else begin
      s1_v_q <= s1_v_d; s2_v_q <= s2_v_d; ovr_q <= ovr_d; fovr_q <= fovr_d;
      irq_q  <= irq_d;  stall_q <= stall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      if (take) s1_q <= frame_word;
      if (mv)   s2_q <= s1_q;
    end
  end

  always_comb begin
    if (fifo_en)     src = SRC_FIFO;
    else if (use_s2) src = SRC_STAGE2;
    else             src = SRC_STAGE1;
    case (src)
      SRC_FIFO:   begin rd_word = head; data_avail = (cnt != '0); end
      SRC_STAGE2: begin rd_word = s2_q; data_avail = s2_v_q;      end
      default:    begin rd_word = s1_q; data_avail = s1_v_q;      end
    endcase
  end

  assign stall_req    = stall;
  assign rx_irq       = irq_q;
  assign ovr_err      = ovr_q;
  assign fifo_ovr_err = fovr_q;
  assign fifo_count   = cnt;
  assign rx_en_clear  = auto_rx_off && fifo_en && stall && !stall_q;

endmodule

// File: rtl/rx_dbuf_chk.sv
module rx_dbuf_chk #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          frame_vld,
  input logic          clk_out_mode,
  input logic          stage2_en,
  input logic          fifo_en,
  input logic          auto_rx_off,
  input logic          rd_data,
  input logic          rd_status,
  input logic [W-1:0]  rd_word,
  input logic          data_avail,
  input logic          stall_req,
  input logic          ovr_err,
  input logic          fifo_ovr_err,
  input logic [CW-1:0] fifo_count,
  input logic          rx_en_clear
);

  a_r13_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_avail && fifo_count == '0 && !stall_req && !ovr_err && !fifo_ovr_err);

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  a_r12_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status && !frame_vld && !flush |=> !ovr_err && !fifo_ovr_err);

  a_r3_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err && !rd_status && !flush |=> ovr_err);

  a_r3_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && data_avail && !rd_data && !flush |=>
      (fifo_en != $past(fifo_en) || stage2_en != $past(stage2_en)
       || clk_out_mode != $past(clk_out_mode))
      || ($stable(rd_word) && data_avail));

  a_r4_no_stall_without_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_mode |-> !stall_req);

  a_r8_clear_with_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_clear |-> stall_req && auto_rx_off && fifo_en);

endmodule

bind rx_dbuf rx_dbuf_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .frame_vld(frame_vld),
  .clk_out_mode(clk_out_mode), .stage2_en(stage2_en), .fifo_en(fifo_en),
  .auto_rx_off(auto_rx_off), .rd_data(rd_data), .rd_status(rd_status),
  .rd_word(rd_word), .data_avail(data_avail), .stall_req(stall_req),
  .ovr_err(ovr_err), .fifo_ovr_err(fifo_ovr_err), .fifo_count(fifo_count),
  .rx_en_clear(rx_en_clear)
);

// File: tb/rx_dbuf_test.sv
module rx_dbuf_test;
  localparam int W = 9;
  localparam int DEPTH = 4;
  localparam int CW = $clog2(DEPTH + 1);
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n, flush, frame_vld, clk_out_mode, stage2_en, fifo_en;
  logic wake_en, nine_bit_mode, auto_rx_off, rd_data, rd_status;
  logic [W-1:0] frame_word;
  logic [CW-1:0] fill_lvl;
  logic [W-1:0] rd_word;
  logic data_avail, stall_req, rx_irq, ovr_err, fifo_ovr_err, rx_en_clear;
  logic [CW-1:0] fifo_count;

  int checks = 0, errors = 0, irq_seen = 0, clr_seen = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rx_dbuf #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .frame_vld(frame_vld),
    .frame_word(frame_word), .clk_out_mode(clk_out_mode), .stage2_en(stage2_en),
    .fifo_en(fifo_en), .wake_en(wake_en), .nine_bit_mode(nine_bit_mode),
    .auto_rx_off(auto_rx_off), .fill_lvl(fill_lvl), .rd_data(rd_data),
    .rd_status(rd_status), .rd_word(rd_word), .data_avail(data_avail),
    .stall_req(stall_req), .rx_irq(rx_irq), .ovr_err(ovr_err),
    .fifo_ovr_err(fifo_ovr_err), .fifo_count(fifo_count), .rx_en_clear(rx_en_clear)
  );

  // ---------------- behavioural reference ----------------
  int q[$];
  bit m1v, m2v, movr, mfovr, mirq, mstq;
  int m1, m2;

  function automatic int m_thr();
    return (fill_lvl == 0 || fill_lvl > DEPTH) ? DEPTH : int'(fill_lvl);
  endfunction
  function automatic bit m_use2();
    return !clk_out_mode || stage2_en || fifo_en;
  endfunction
  function automatic bit m_pass(int w);
    return !(wake_en && nine_bit_mode) || w[8];
  endfunction
  function automatic bit m_stall();
    if (!clk_out_mode) return 0;
    if (!m_use2()) return m1v;
    if (!fifo_en) return m1v && m2v;
    return q.size() >= m_thr() && m1v && m2v;
  endfunction

  task automatic m_clear();
    q.delete(); m1v = 0; m2v = 0; movr = 0; mfovr = 0; mirq = 0; mstq = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || flush) m_clear();
    else begin
      bit v1, v2, irqn, u2, dropped;
      int n1, n2;
      u2 = m_use2(); irqn = 0; dropped = 0;
      v1 = m1v; v2 = m2v; n1 = m1; n2 = m2;
      mstq <= m_stall();
      if (rd_data && fifo_en && q.size() > 0) void'(q.pop_front());
      if (fifo_en && v2 && q.size() < m_thr()) begin
        q.push_back(m2); v2 = 0; if (m_pass(m2)) irqn = 1;
      end
      if (!fifo_en && u2 && rd_data) v2 = 0;
      if (u2 && v1 && !v2) begin
        n2 = m1; v2 = 1; v1 = 0; if (!fifo_en && m_pass(m1)) irqn = 1;
      end
      if (!u2 && rd_data) v1 = 0;
      if (frame_vld) begin
        if (!v1) begin
          v1 = 1; n1 = int'(frame_word);
          if (!u2 && m_pass(int'(frame_word))) irqn = 1;
        end else dropped = 1;
      end
      movr  = (dropped && !fifo_en) || (movr && !rd_status);
      mfovr = (dropped && fifo_en) || (mfovr && !rd_status);
      m1v = v1; m2v = v2; m1 = n1; m2 = n2; mirq = irqn;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int eavail, eword;
    if (fifo_en) begin eavail = q.size() > 0; eword = eavail ? q[0] : 0; end
    else if (m_use2()) begin eavail = m2v; eword = m2; end
    else begin eavail = m1v; eword = m1; end
    chk("R1 data_avail vs model", data_avail, eavail);
    if (eavail != 0) chk("R1 rd_word vs model", rd_word, eword);
    chk("R5 stall_req vs model", stall_req, m_stall());
    chk("R11 rx_irq vs model", rx_irq, mirq);
    chk("R3 ovr_err vs model", ovr_err, movr);
    chk("R7 fifo_ovr_err vs model", fifo_ovr_err, mfovr);
    chk("R6 fifo_count vs model", fifo_count, q.size());
    chk("R8 rx_en_clear vs model", rx_en_clear,
        auto_rx_off && fifo_en && m_stall() && !mstq);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    if (rx_irq) irq_seen++;
    if (rx_en_clear) clr_seen++;
    compare();
  endtask

  task automatic send(int w);
    frame_vld = 1; frame_word = W'(w); cyc();
    frame_vld = 0; cyc();
  endtask

  task automatic rd();
    rd_data = 1; cyc(); rd_data = 0; cyc();
  endtask

  task automatic do_flush();
    flush = 1; cyc(); flush = 0; cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    rst_n = 0; flush = 0; frame_vld = 0; frame_word = '0; clk_out_mode = 0;
    stage2_en = 1; fifo_en = 0; wake_en = 0; nine_bit_mode = 0; auto_rx_off = 0;
    fill_lvl = '0; rd_data = 0; rd_status = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R13: reset state
    chk("R13 reset data_avail", data_avail, 0);
    chk("R13 reset stall_req", stall_req, 0);
    chk("R13 reset ovr_err", ovr_err, 0);
    chk("R13 reset fifo_count", fifo_count, 0);

    // R11: interrupt pulse, word enters stage 1 then stage 2
    frame_vld = 1; frame_word = 9'h0A5; cyc();
    chk("R11 irq before readable", rx_irq, 0);
    frame_vld = 0; cyc();
    chk("R11 irq when readable", rx_irq, 1);
    cyc();
    chk("R11 irq single cycle", rx_irq, 0);

    // R2, R3, R9, R1, R12
    send(9'h1B3);
    chk("R2 no overrun with two held", ovr_err, 0);
    chk("R2 first word still visible", rd_word, 9'h0A5);
    send(9'h011);
    chk("R3 overrun flagged", ovr_err, 1);
    chk("R3 unread word kept", rd_word, 9'h0A5);
    rd();
    chk("R9 ninth bit kept", rd_word, 9'h1B3);
    rd();
    chk("R1 read empties", data_avail, 0);
    chk("R3 overrun sticky", ovr_err, 1);
    rd_status = 1; cyc(); rd_status = 0;
    chk("R12 status read clears", ovr_err, 0);

    // R4: clock-out, single stage
    clk_out_mode = 1; stage2_en = 0; do_flush();
    send(9'h044);
    chk("R4 stall after frame", stall_req, 1);
    chk("R4 stage1 readable", rd_word, 9'h044);
    rd();
    chk("R4 read releases stall", stall_req, 0);
    chk("R4 stage1 consumed", data_avail, 0);

    // R5: clock-out, two stages
    stage2_en = 1; do_flush();
    send(9'h001);
    chk("R5 one word no stall", stall_req, 0);
    send(9'h002);
    chk("R5 both full stall", stall_req, 1);
    rd_data = 1; cyc(); rd_data = 0;
    chk("R5 moved word irq", rx_irq, 1);
    chk("R5 stall released", stall_req, 0);
    chk("R5 second word visible", rd_word, 9'h002);
    cyc();

    // R6, R7: FIFO, no clock output
    clk_out_mode = 0; fifo_en = 1; fill_lvl = CW'(4); do_flush();
    for (int i = 0; i < 6; i++) send(9'h101 + i);
    idle(4);
    chk("R6 fifo at threshold", fifo_count, 4);
    chk("R6 head is first", rd_word, 9'h101);
    send(9'h107);
    chk("R7 fifo overrun flagged", fifo_ovr_err, 1);
    chk("R7 fifo count kept", fifo_count, 4);
    for (int i = 0; i < 6; i++) begin
      chk("R6 arrival order", rd_word, 9'h101 + i);
      rd();
    end
    chk("R6 all drained", data_avail, 0);
    rd_status = 1; cyc(); rd_status = 0; cyc();

    // R8: clock-out with FIFO, threshold 2, auto receiver off
    clk_out_mode = 1; fill_lvl = CW'(2); auto_rx_off = 1; do_flush();
    clr_seen = 0;
    for (int i = 0; i < 4; i++) send(9'h020 + i);
    chk("R8 stall at threshold", stall_req, 1);
    chk("R8 fifo holds threshold", fifo_count, 2);
    chk("R8 one clear pulse", clr_seen, 1);
    rd();
    chk("R8 read releases stall", stall_req, 0);

    // R14: threshold 0 means full depth
    fill_lvl = '0; auto_rx_off = 0; do_flush();
    for (int i = 0; i < 5; i++) send(9'h030 + i);
    chk("R14 no stall below depth", stall_req, 0);
    send(9'h035);
    chk("R14 stall at full depth", stall_req, 1);
    chk("R14 count equals depth", fifo_count, DEPTH);

    // R10: wake-up filter
    clk_out_mode = 0; fifo_en = 0; stage2_en = 1; nine_bit_mode = 1; wake_en = 1;
    do_flush();
    irq_seen = 0;
    send(9'h055);
    chk("R10 clear bit8 no irq", irq_seen, 0);
    chk("R10 word still stored", data_avail, 1);
    rd();
    send(9'h155);
    chk("R10 set bit8 irq", irq_seen, 1);

    // R13: flush drops held data
    send(9'h066);
    do_flush();
    chk("R13 flush empties", data_avail, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule